// File: doc/BRIEF.md
# Width-Selectable Processor Status Flag Unit

This block keeps the low byte of a processor status word and decides, each clock, how its flags change. The ALU datapath passes in a result, the two operands that produced it and a class code for the operation. It also passes two overflow indicators of its own, one from the divider and one from the 32-bit multiply-accumulate loop. From these inputs the block derives the overflow and negative flags.

Bit 5 of the byte is a width selector. When it is clear, the sign and overflow rules work on 16-bit words. When it is set, they work on the low 8 bits and ignore the upper byte. Instruction decode can force any chosen bits high or low with mask commands, and dedicated strobes touch only the width bit or the overflow bit. A pull from the stack replaces the whole byte at once.

The stored byte and four branch-condition lines come straight from the register. These lines are: overflow clear, overflow set, plus and minus.

Top module: `stat_flag_core`

## Requirements
- R1: After reset all eight status bits read 0, so the overflow-clear and plus branch lines are 1 and the overflow-set and minus lines are 0.
- R2: For class 1 (add, or subtract when `op_sub`=1) with bit 5 clear, bit 6 becomes 1 exactly when the signed 16-bit result falls outside -32768..+32767, and 0 otherwise.
- R3: For class 1 with bit 5 set, bit 6 becomes 1 exactly when the signed result of the low operand bytes falls outside -128..+127. The upper bytes of the operands and of the result have no effect.
- R4: For class 1 and class 2 (transfer), bit 7 takes result bit 15 when bit 5 is clear and result bit 7 when bit 5 is set. A transfer leaves bit 6 unchanged.
- R5: For class 3 (divide), bit 6 takes `div_ovf` and bit 7 takes the result sign at the active width.
- R6: For class 4 (multiply-accumulate), bit 6 takes `macc_ovf` and bit 7 is unchanged.
- R7: For class 5 (decimal arithmetic), bits 6 and 7 are unchanged.
- R8: `set_mask_en` sets every bit selected by `flag_mask` and `clr_mask_en` clears them. If both select a bit in one cycle, the bit is cleared.
- R9: `width_set` sets bit 5, `width_clr` clears bit 5 and `ovf_clr` clears bit 6. Each leaves every other bit unchanged.
- R10: `restore_en` loads `restore_byte` into all eight bits, overriding any mask command or ALU update in the same cycle.
- R11: A mask or dedicated command on bit 6 or 7 overrides the ALU-driven value of that bit in the same cycle. The ALU update in that cycle uses the width bit as it was before the cycle.
- R12: `br_ovf_clr`/`br_ovf_set` equal the inverse/true value of bit 6 and `br_plus`/`br_minus` the inverse/true value of bit 7. All four follow the register with no added delay.
- R13: With `op_valid` low, or with class 0 or classes 6 and 7, and no mask, dedicated or restore command, the byte holds its value.
- R14: Every update is visible on `flags_o` after the rising clock edge that captured the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | ALU result valid this cycle |
| op_class | input | 3 | 0 none, 1 add/sub, 2 transfer, 3 divide, 4 multiply-accumulate, 5 decimal |
| op_sub | input | 1 | Class 1 is a subtraction |
| opnd_a | input | 16 | First ALU operand |
| opnd_b | input | 16 | Second ALU operand |
| alu_result | input | 16 | ALU result |
| div_ovf | input | 1 | Divide result does not fit the destination |
| macc_ovf | input | 1 | Accumulated sum left the signed 32-bit range |
| set_mask_en | input | 1 | Set the bits chosen by `flag_mask` |
| clr_mask_en | input | 1 | Clear the bits chosen by `flag_mask` |
| flag_mask | input | 8 | Bit selection for mask commands |
| width_set | input | 1 | Set the width bit only |
| width_clr | input | 1 | Clear the width bit only |
| ovf_clr | input | 1 | Clear the overflow bit only |
| restore_en | input | 1 | Load the whole byte from `restore_byte` |
| restore_byte | input | 8 | Byte pulled from the stack |
| flags_o | output | 8 | Stored status byte |
| br_ovf_clr | output | 1 | Overflow-clear branch condition |
| br_ovf_set | output | 1 | Overflow-set branch condition |
| br_plus | output | 1 | Plus branch condition |
| br_minus | output | 1 | Minus branch condition |

## Verification
A corrupted bit in the stored byte appears on `flags_o` in the cycle after the edge that wrote it. If the bit is overflow or sign, it also appears at once on two branch lines. A wrong width bit cannot be seen directly in flag values. It shows up only on the next add/sub whose 8-bit and 16-bit overflow or sign differ, so the random sequence mixes width changes with carry-crossing operands and checks every cycle. A priority fault is visible only when commands collide, so the stimulus places restore, mask and ALU updates deliberately in the same cycle.

// File: rtl/sfu_pkg.sv
package sfu_pkg;

   typedef enum logic [2:0] {
      OPC_NONE   = 3'd0,
      OPC_ADDSUB = 3'd1,
      OPC_MOVE   = 3'd2,
      OPC_DIV    = 3'd3,
      OPC_MACC   = 3'd4,
      OPC_BCD    = 3'd5
   } opc_e;

   // bit positions inside the status byte that other logic decodes
   localparam int unsigned BIT_WIDTHSEL = 5;
   localparam int unsigned BIT_OVF      = 6;
   localparam int unsigned BIT_NEG      = 7;

endpackage

// File: rtl/sfu_arith_eval.sv
module sfu_arith_eval #(
   parameter int unsigned WORD_W   = 16,
   parameter int unsigned NARROW_W = 8
) (
   input  logic              narrow,
   input  logic              sub,
   input  logic [WORD_W-1:0] a,
   input  logic [WORD_W-1:0] b,
   input  logic [WORD_W-1:0] r,
   output logic              sign,
   output logic              ovf
);

   localparam int unsigned N_MODES = 2;

   logic [N_MODES-1:0] sgn_m;
   logic [N_MODES-1:0] ovf_m;

   // both widths are evaluated side by side, the stored width bit picks one
   generate
      for (genvar g = 0; g < N_MODES; g++) begin : g_mode
         localparam int unsigned MSB = (g == 0) ? WORD_W - 1 : NARROW_W - 1;
         logic a_s, b_s, r_s;
         assign a_s      = a[MSB];
         assign b_s      = b[MSB] ^ sub;
         assign r_s      = r[MSB];
         assign sgn_m[g] = r_s;
         assign ovf_m[g] = (a_s == b_s) && (r_s != a_s);
      end
   endgenerate

   assign sign = sgn_m[narrow];
   assign ovf  = ovf_m[narrow];

endmodule

// File: rtl/sfu_alu_update.sv
module sfu_alu_update
   import sfu_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic op_valid,
   input  opc_e opc,
   input  logic sign,
   input  logic ovf,
   input  logic div_ovf,
   input  logic macc_ovf,
   output logic we_ovf,
   output logic we_neg,
   output logic val_ovf,
   output logic val_neg
);

   always_comb begin
      we_ovf  = 1'b0;
      we_neg  = 1'b0;
      val_ovf = 1'b0;
      val_neg = sign;
      if (op_valid) begin
         unique case (opc)
            OPC_ADDSUB: begin
               we_ovf  = 1'b1;
               we_neg  = 1'b1;
               val_ovf = ovf;
            end
            OPC_MOVE: we_neg = 1'b1;
            OPC_DIV: begin
               we_ovf  = 1'b1;
               we_neg  = 1'b1;
               val_ovf = div_ovf;
            end
            OPC_MACC: begin
               we_ovf  = 1'b1;
               val_ovf = macc_ovf;
            end
            default: ;
         endcase
      end
   end

   // R7: decimal arithmetic must never request a write of overflow or sign
   assert_bcd_hold_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && opc == OPC_BCD) |-> (!we_ovf && !we_neg));

   // R6: multiply-accumulate leaves the sign alone
   assert_macc_sign_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && opc == OPC_MACC) |-> !we_neg);

endmodule

// File: rtl/sfu_flag_bank.sv
module sfu_flag_bank #(
   parameter int unsigned STAT_W    = 8,
   parameter logic [STAT_W-1:0] RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restore_en,
   input  logic [STAT_W-1:0] restore_val,
   input  logic [STAT_W-1:0] set_vec,
   input  logic [STAT_W-1:0] clr_vec,
   input  logic [STAT_W-1:0] alu_we,
   input  logic [STAT_W-1:0] alu_val,
   output logic [STAT_W-1:0] flags
);

   logic [STAT_W-1:0] nxt;

   // per bit: stack restore, then clear, then set, then ALU, else hold
   generate
      for (genvar i = 0; i < STAT_W; i++) begin : g_bit
         assign nxt[i] = restore_en ? restore_val[i] :
                         clr_vec[i] ? 1'b0 :
                         set_vec[i] ? 1'b1 :
                         alu_we[i]  ? alu_val[i] : flags[i];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= RESET_VAL;
      else        flags <= nxt;
   end

   assert_restore_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      restore_en |=> (flags == $past(restore_val)));

   assert_clear_wins_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (!restore_en && clr_vec != '0) |=> ((flags & $past(clr_vec)) == '0));

   assert_set_mask_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (!restore_en && set_vec != '0)
      |=> ((flags & $past(set_vec & ~clr_vec)) == $past(set_vec & ~clr_vec)));

   assert_idle_hold_R13 : assert property (@(posedge clk) disable iff (!rst_n)
      (!restore_en && set_vec == '0 && clr_vec == '0 && alu_we == '0) |=> $stable(flags));

endmodule

// File: rtl/stat_flag_core.sv
module stat_flag_core
   import sfu_pkg::*;
#(
   parameter int unsigned WORD_W   = 16,
   parameter int unsigned NARROW_W = 8,
   parameter int unsigned STAT_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_class,
   input  logic              op_sub,
   input  logic [WORD_W-1:0] opnd_a,
   input  logic [WORD_W-1:0] opnd_b,
   input  logic [WORD_W-1:0] alu_result,
   input  logic              div_ovf,
   input  logic              macc_ovf,
   input  logic              set_mask_en,
   input  logic              clr_mask_en,
   input  logic [STAT_W-1:0] flag_mask,
   input  logic              width_set,
   input  logic              width_clr,
   input  logic              ovf_clr,
   input  logic              restore_en,
   input  logic [STAT_W-1:0] restore_byte,
   output logic [STAT_W-1:0] flags_o,
   output logic              br_ovf_clr,
   output logic              br_ovf_set,
   output logic              br_plus,
   output logic              br_minus
);

   localparam logic [STAT_W-1:0] ONE_HOT_W = STAT_W'(1) << BIT_WIDTHSEL;
   localparam logic [STAT_W-1:0] ONE_HOT_V = STAT_W'(1) << BIT_OVF;
   localparam logic [STAT_W-1:0] ONE_HOT_N = STAT_W'(1) << BIT_NEG;

   generate
      if (NARROW_W < 1 || NARROW_W >= WORD_W) begin : g_bad_width
         $error("stat_flag_core: NARROW_W must lie in 1..WORD_W-1");
      end
      if (STAT_W < 8) begin : g_bad_stat
         $error("stat_flag_core: STAT_W must hold bits 0..7");
      end
   endgenerate

   logic              narrow;
   logic              ev_sign, ev_ovf;
   logic              we_ovf, we_neg, val_ovf, val_neg;
   logic [STAT_W-1:0] set_vec, clr_vec, alu_we, alu_val;
   opc_e              opc;

   assign narrow = flags_o[BIT_WIDTHSEL];
   assign opc    = opc_e'(op_class);

   sfu_arith_eval #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_eval (
      .narrow (narrow),
      .sub    (op_sub),
      .a      (opnd_a),
      .b      (opnd_b),
      .r      (alu_result),
      .sign   (ev_sign),
      .ovf    (ev_ovf)
   );

   sfu_alu_update u_upd (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_valid (op_valid),
      .opc      (opc),
      .sign     (ev_sign),
      .ovf      (ev_ovf),
      .div_ovf  (div_ovf),
      .macc_ovf (macc_ovf),
      .we_ovf   (we_ovf),
      .we_neg   (we_neg),
      .val_ovf  (val_ovf),
      .val_neg  (val_neg)
   );

   always_comb begin
      set_vec = set_mask_en ? flag_mask : '0;
      clr_vec = clr_mask_en ? flag_mask : '0;
      if (width_set) set_vec = set_vec | ONE_HOT_W;
      if (width_clr) clr_vec = clr_vec | ONE_HOT_W;
      if (ovf_clr)   clr_vec = clr_vec | ONE_HOT_V;
      alu_we  = (we_ovf ? ONE_HOT_V : '0) | (we_neg ? ONE_HOT_N : '0);
      alu_val = (val_ovf ? ONE_HOT_V : '0) | (val_neg ? ONE_HOT_N : '0);
   end

   sfu_flag_bank #(.STAT_W(STAT_W)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .restore_en  (restore_en),
      .restore_val (restore_byte),
      .set_vec     (set_vec),
      .clr_vec     (clr_vec),
      .alu_we      (alu_we),
      .alu_val     (alu_val),
      .flags       (flags_o)
   );

   assign br_ovf_set = flags_o[BIT_OVF];
   assign br_ovf_clr = ~flags_o[BIT_OVF];
   assign br_minus   = flags_o[BIT_NEG];
   assign br_plus    = ~flags_o[BIT_NEG];

   // R9: the dedicated width strobe alone moves only the width bit
   assert_width_only_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (width_set && !restore_en && !set_mask_en && !clr_mask_en && !width_clr
       && !ovf_clr && !op_valid)
      |=> (flags_o == ($past(flags_o) | ONE_HOT_W)));

   // R5: a divide with no competing command copies the divider's overflow
   assert_div_ovf_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && opc == OPC_DIV && !restore_en && !set_mask_en && !clr_mask_en
       && !ovf_clr) |=> (flags_o[BIT_OVF] == $past(div_ovf)));

endmodule

// File: tb/test_stat_flag_core.sv
`timescale 1ns/1ps
module test_stat_flag_core;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 0, op_sub = 0, div_ovf = 0, macc_ovf = 0;
   logic [2:0]  op_class = 0;
   logic [15:0] opnd_a = 0, opnd_b = 0, alu_result = 0;
   logic        set_mask_en = 0, clr_mask_en = 0, width_set = 0, width_clr = 0, ovf_clr = 0;
   logic        restore_en = 0;
   logic [7:0]  flag_mask = 0, restore_byte = 0;
   logic [7:0]  flags_o;
   logic        br_ovf_clr, br_ovf_set, br_plus, br_minus;

   int vectors = 0;
   int errors  = 0;
   logic [7:0] mdl = 8'h00;

   typedef struct { logic [7:0] flags; string req; } exp_t;
   exp_t sb[$];

   always #10 clk = ~clk;   // 50 MHz

   stat_flag_core i_stat_flag_core (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
      .op_sub(op_sub), .opnd_a(opnd_a), .opnd_b(opnd_b), .alu_result(alu_result),
      .div_ovf(div_ovf), .macc_ovf(macc_ovf), .set_mask_en(set_mask_en),
      .clr_mask_en(clr_mask_en), .flag_mask(flag_mask), .width_set(width_set),
      .width_clr(width_clr), .ovf_clr(ovf_clr), .restore_en(restore_en),
      .restore_byte(restore_byte), .flags_o(flags_o), .br_ovf_clr(br_ovf_clr),
      .br_ovf_set(br_ovf_set), .br_plus(br_plus), .br_minus(br_minus));

   task automatic compare(input logic [7:0] exp, input string req);
      logic [3:0] br_got, br_exp;
      vectors++;
      br_got = {br_ovf_clr, br_ovf_set, br_plus, br_minus};
      br_exp = {~exp[6], exp[6], ~exp[7], exp[7]};   // R12
      if (flags_o !== exp || br_got !== br_exp) begin
         errors++;
         $display("FAIL %s: flags=%h br=%b expected flags=%h br=%b",
                  req, flags_o, br_got, exp, br_exp);
      end
   endtask

   // monitor: one expected item per captured cycle, checked after the edge (R14)
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            compare(e.flags, e.req);
         end
      end
   end

   // independent reference: range checks on signed integers at the active width
   function automatic logic [7:0] predict(input logic [7:0] cur);
      logic [7:0] n;
      logic nar;
      int sa, sb_v, s;
      logic rng_ovf, sgn;
      n   = cur;
      nar = cur[5];
      sa   = nar ? int'($signed(opnd_a[7:0])) : int'($signed(opnd_a));
      sb_v = nar ? int'($signed(opnd_b[7:0])) : int'($signed(opnd_b));
      s    = op_sub ? sa - sb_v : sa + sb_v;
      rng_ovf = nar ? (s < -128 || s > 127) : (s < -32768 || s > 32767);
      sgn  = nar ? alu_result[7] : alu_result[15];
      if (op_valid) begin
         case (op_class)
            3'd1: begin n[6] = rng_ovf; n[7] = sgn; end
            3'd2: n[7] = sgn;
            3'd3: begin n[6] = div_ovf; n[7] = sgn; end
            3'd4: n[6] = macc_ovf;
            default: ;
         endcase
      end
      if (set_mask_en) n = n | flag_mask;
      if (width_set)   n[5] = 1'b1;
      if (clr_mask_en) n = n & ~flag_mask;
      if (width_clr)   n[5] = 1'b0;
      if (ovf_clr)     n[6] = 1'b0;
      if (restore_en)  n = restore_byte;
      return n;
   endfunction

   task automatic clear_inputs();
      op_valid = 0; op_class = 0; op_sub = 0; opnd_a = 0; opnd_b = 0; alu_result = 0;
      div_ovf = 0; macc_ovf = 0; set_mask_en = 0; clr_mask_en = 0; flag_mask = 0;
      width_set = 0; width_clr = 0; ovf_clr = 0; restore_en = 0; restore_byte = 0;
   endtask

   // driver: inputs must already be set by the caller's closure via args
   task automatic push(input string req);
      exp_t e;
      e.flags = predict(mdl);
      e.req   = req;
      mdl     = e.flags;
      sb.push_back(e);
   endtask

   task automatic alu_op(input logic [2:0] cls, input logic sub,
                         input logic [15:0] a, input logic [15:0] b,
                         input logic [7:0] hi_junk, input string req);
      logic [15:0] r;
      @(negedge clk);
      clear_inputs();
      r = sub ? a - b : a + b;
      if (mdl[5]) r[15:8] = hi_junk;
      op_valid = 1; op_class = cls; op_sub = sub;
      opnd_a = a; opnd_b = b; alu_result = r;
      push(req);
   endtask

   task automatic idle(input string req);
      @(negedge clk);
      clear_inputs();
      push(req);
   endtask

   initial begin
      clear_inputs();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare(8'h00, "R1 reset");

      // R2: 16-bit signed add/sub
      alu_op(3'd1, 0, 16'h7FFF, 16'h0001, 8'h00, "R2 add ovf 16");
      alu_op(3'd1, 0, 16'h1234, 16'h0001, 8'h00, "R2 add no ovf 16");
      alu_op(3'd1, 1, 16'h8000, 16'h0001, 8'h00, "R2 sub ovf 16");
      alu_op(3'd1, 0, 16'h007F, 16'h0001, 8'h00, "R2 byte carry ignored at 16");
      // R9: width set only
      @(negedge clk); clear_inputs(); width_set = 1; push("R9 width set");
      // R3: 8-bit ranges, upper bytes are junk
      alu_op(3'd1, 0, 16'h007F, 16'h0001, 8'hA5, "R3 add ovf 8");
      alu_op(3'd1, 0, 16'h7F10, 16'h0001, 8'h3C, "R3 upper ignored");
      alu_op(3'd1, 1, 16'hFF80, 16'h0001, 8'h00, "R3 sub ovf 8");
      // R4: transfer sign at narrow width, V held
      alu_op(3'd1, 0, 16'h007F, 16'h0001, 8'h00, "R3 set V");
      alu_op(3'd2, 0, 16'h0005, 16'h0000, 8'hFF, "R4 move plus hi junk");
      alu_op(3'd2, 0, 16'h0080, 16'h0000, 8'h00, "R4 move minus 8");
      // R5/R6/R7
      @(negedge clk); clear_inputs(); op_valid = 1; op_class = 3'd3; div_ovf = 1;
      alu_result = 16'h0012; push("R5 div ovf");
      @(negedge clk); clear_inputs(); op_valid = 1; op_class = 3'd4; macc_ovf = 0;
      alu_result = 16'h00FF; push("R6 macc clears V keeps N");
      @(negedge clk); clear_inputs(); op_valid = 1; op_class = 3'd4; macc_ovf = 1;
      push("R6 macc ovf");
      alu_op(3'd5, 0, 16'h007F, 16'h0001, 8'h00, "R7 decimal holds");
      // R9: other dedicated strobes
      @(negedge clk); clear_inputs(); ovf_clr = 1; push("R9 ovf clear");
      @(negedge clk); clear_inputs(); width_clr = 1; push("R9 width clear");
      // R8: masks, clear wins on collision
      @(negedge clk); clear_inputs(); set_mask_en = 1; flag_mask = 8'h9B; push("R8 set mask");
      @(negedge clk); clear_inputs(); clr_mask_en = 1; flag_mask = 8'h0A; push("R8 clr mask");
      @(negedge clk); clear_inputs(); set_mask_en = 1; clr_mask_en = 1; flag_mask = 8'h44;
      push("R8 clear wins");
      // R11: mask beats ALU on the same bit
      @(negedge clk); clear_inputs(); op_valid = 1; op_class = 3'd1;
      opnd_a = 16'h7FFF; opnd_b = 16'h0001; alu_result = 16'h8000; ovf_clr = 1;
      set_mask_en = 1; flag_mask = 8'h20; push("R11 mask over ALU, old width");
      // R10: restore beats everything
      @(negedge clk); clear_inputs(); restore_en = 1; restore_byte = 8'h3C;
      set_mask_en = 1; flag_mask = 8'hC0; op_valid = 1; op_class = 3'd3; div_ovf = 1;
      push("R10 restore priority");
      // R13: idle and undefined classes hold
      idle("R13 idle hold");
      @(negedge clk); clear_inputs(); op_valid = 1; op_class = 3'd7;
      alu_result = 16'hFFFF; push("R13 class 7 hold");
      @(negedge clk); clear_inputs(); op_class = 3'd1; opnd_a = 16'h7FFF;
      opnd_b = 16'h0001; alu_result = 16'h8000; push("R13 valid low hold");

      // random mix in both widths
      for (int k = 0; k < 600; k++) begin
         logic [2:0] cls;
         cls = 3'($urandom_range(0, 7));
         @(negedge clk);
         clear_inputs();
         op_valid = ($urandom_range(0, 5) != 0);
         op_class = cls;
         op_sub   = 1'($urandom);
         opnd_a   = 16'($urandom);
         opnd_b   = 16'($urandom);
         alu_result = op_sub ? opnd_a - opnd_b : opnd_a + opnd_b;
         if (mdl[5]) alu_result[15:8] = 8'($urandom);
         div_ovf  = 1'($urandom);
         macc_ovf = 1'($urandom);
         if ($urandom_range(0, 7) == 0) begin set_mask_en = 1; flag_mask = 8'($urandom); end
         if ($urandom_range(0, 7) == 0) begin clr_mask_en = 1; flag_mask = 8'($urandom); end
         width_set = ($urandom_range(0, 5) == 0);
         width_clr = ($urandom_range(0, 5) == 0);
         ovf_clr   = ($urandom_range(0, 9) == 0);
         if ($urandom_range(0, 19) == 0) begin restore_en = 1; restore_byte = 8'($urandom); end
         push("R2 R3 R4 R5 R6 R7 R8 R11 random");
      end
      idle("R13 final");
      repeat (3) @(negedge clk);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      vectors++;
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule